// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block computes one N×N output tile of an integer matrix product C = A·B on a square grid of multiply-accumulate cells. Each cell owns one element of C and keeps it in its own accumulator for the whole tile. Partial sums never move between cells. Only the operands travel: values of A march rightward along the rows, and values of B march downward along the columns, one register hop per cycle.

A tile begins with a one-cycle `start` pulse. The caller then presents K operand steps. At step k, lane i of `in_a` carries A[i][k] and lane j of `in_b` carries B[k][j]. Each step is qualified by `in_valid`. Inside the block, row i and column j are delayed by i and j cycles, so that matching operands meet in cell (i,j). After the last step, the block pushes zeros through the grid on its own until every cell has finished. It then raises `done`. Any element of C can then be read combinationally by row and column index.

`rst_n` is asserted asynchronously and released synchronously inside the block, two clock edges after the pin rises. The grid must be at least 2×2.

Top module: `os_systolic_mm`

## Requirements
- R1: After reset, `done` is 0 and every element read through `rd_row`/`rd_col` returns 0.
- R2: When `done` is 1, `rd_data` at (`rd_row`=i, `rd_col`=j) equals the signed sum over the K accepted steps of A[i][k]·B[k][j]. Operands are 8-bit two's complement. Lane i of `in_a` (and lane j of `in_b`) occupies bits [8i+7:8i].
- R3: The accumulator is 16+ceil(log2 K) bits wide. K products of the extreme value −128·−128 give exactly 16384·K. K products of −128·127 give exactly −16256·K. No read ever leaves the range [−16256·K, 16384·K].
- R4: With `in_valid` held high for K consecutive cycles after `start`, `done` reads 1 after clock edge K+2N−1 and 0 after every earlier edge. Edge 1 is the edge that accepts the first step.
- R5: A cycle with `in_valid` low during the feed phase accepts no operand. Each such cycle delays `done` by exactly one cycle. The result equals that of the same steps given without gaps.
- R6: `start` clears all accumulators and `done`, including in the middle of a tile. Steps accepted before a restart do not contribute to the result.
- R7: `in_valid` and operand values are ignored when the block is not feeding: in the same cycle as `start`, after the K-th step, and while `done` is 1. In those cases `done` and the results do not change.
- R8: Once set, `done` and all results stay unchanged until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that clears the tile and begins a new one |
| in_valid | input | 1 | Qualifies `in_a`/`in_b` as the next accumulation step |
| in_a | input | 8·N | Column k of A, lane i = row i, signed |
| in_b | input | 8·N | Row k of B, lane j = column j, signed |
| rd_row | input | ceil(log2 N) | Row index of the result to read |
| rd_col | input | ceil(log2 N) | Column index of the result to read |
| done | output | 1 | Tile finished, results valid |
| rd_data | output | 16+ceil(log2 K) | Selected accumulator, signed |

## Verification
The product is exercised with several operand patterns:
- Scrambled mixed-sign operands catch wrong lane ordering or a wrong skew, because a single misaligned step spoils every cell.
- A signed ramp crossed with a ±1 selector separates the sign handling of the two operand streams.
- The extreme patterns of −128 with −128 and −128 with 127 expose a narrow accumulator or a lost sign extension.
- Gapped feeds show whether stalls freeze the whole grid or only the edge.

Junk offered with `in_valid` in non-feed cycles, and a restart in the middle of a tile, tell apart a block that truly ignores or discards operands from one that leaks them into the accumulators. A per-cycle comparison of `done` pins its latency under each stall pattern.

// File: rtl/os_sa_pkg.sv
package os_sa_pkg;

  localparam int OPW = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FEED  = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DONE  = 2'd3
  } sa_state_e;

  // accumulator width: full product plus growth over k_len additions
  function automatic int acc_width(input int k_len);
    return 2 * OPW + $clog2(k_len);
  endfunction

endpackage

// File: rtl/os_sa_skew.sv
// Per-lane delay line at the array edge; DEPTH = 0 is a plain wire.
module os_sa_skew #(
  parameter int DEPTH = 1,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  if (DEPTH == 0) begin : g_pass
    assign dout = din;
  end else begin : g_delay
    logic [W-1:0] sr_q [DEPTH];
    logic [W-1:0] sr_d [DEPTH];

    always_comb begin
      sr_d[0] = din;
      for (int s = 1; s < DEPTH; s++) sr_d[s] = sr_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < DEPTH; s++) sr_q[s] <= '0;
      end else if (clr) begin
        for (int s = 0; s < DEPTH; s++) sr_q[s] <= '0;
      end else if (adv) begin
        for (int s = 0; s < DEPTH; s++) sr_q[s] <= sr_d[s];
      end
    end

    assign dout = sr_q[DEPTH-1];
  end

endmodule

// File: rtl/os_sa_pe.sv
// One output-stationary cell: accumulates a*b in place when the grid advances.
module os_sa_pe #(
  parameter int OPW   = 8,
  parameter int ACC_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    adv,
  input  logic signed [OPW-1:0]   a_in,
  input  logic signed [OPW-1:0]   b_in,
  output logic signed [ACC_W-1:0] acc
);

  logic signed [2*OPW-1:0] prod;
  logic signed [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    prod  = a_in * b_in;
    acc_d = acc_q + ACC_W'(prod);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clr)   acc_q <= '0;
    else if (adv)   acc_q <= acc_d;
  end

  assign acc = acc_q;

endmodule

// File: rtl/os_sa_ctrl.sv
// Tile sequencer: feed K steps, flush 2N-1 steps, then hold done.
module os_sa_ctrl
  import os_sa_pkg::*;
#(
  parameter int N = 4,
  parameter int K = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  output logic adv,
  output logic feed,
  output logic clr,
  output logic done
);

  localparam int TOTAL = K + 2 * N - 1;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] LAST_FEED  = CW'(K - 1);
  localparam logic [CW-1:0] LAST_FLUSH = CW'(TOTAL - 1);

  sa_state_e      state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           done_q, done_d;

  always_comb begin
    adv     = !start && (((state_q == ST_FEED) && in_valid) || (state_q == ST_FLUSH));
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    if (start) begin
      state_d = ST_FEED;
      cnt_d   = '0;
      done_d  = 1'b0;
    end else if (adv) begin
      cnt_d = cnt_q + 1'b1;
      if ((state_q == ST_FEED) && (cnt_q == LAST_FEED)) state_d = ST_FLUSH;
      if ((state_q == ST_FLUSH) && (cnt_q == LAST_FLUSH)) begin
        state_d = ST_DONE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign feed = (state_q == ST_FEED) && !start;
  assign clr  = start;
  assign done = done_q;

endmodule

// File: rtl/os_systolic_mm.sv
module os_systolic_mm #(
  parameter  int N     = 4,
  parameter  int K     = 16,
  localparam int OPW   = os_sa_pkg::OPW,
  localparam int ACC_W = os_sa_pkg::acc_width(K),
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             in_valid,
  input  logic [N*OPW-1:0] in_a,
  input  logic [N*OPW-1:0] in_b,
  input  logic [IW-1:0]    rd_row,
  input  logic [IW-1:0]    rd_col,
  output logic             done,
  output logic [ACC_W-1:0] rd_data
);

  // reset: asserted asynchronously, released on the second edge
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  logic rst_core_n;
  assign rst_core_n = rst_s2_q;

  logic adv, feed, clr;

  os_sa_ctrl #(.N(N), .K(K)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .start    (start),
    .in_valid (in_valid),
    .adv      (adv),
    .feed     (feed),
    .clr      (clr),
    .done     (done)
  );

  logic [OPW-1:0] a_edge [N];
  logic [OPW-1:0] b_edge [N];

  for (genvar l = 0; l < N; l++) begin : g_lane
    logic [OPW-1:0] a_gate, b_gate;
    assign a_gate = feed ? in_a[l*OPW +: OPW] : '0;
    assign b_gate = feed ? in_b[l*OPW +: OPW] : '0;

    os_sa_skew #(.DEPTH(l), .W(OPW)) u_skew_a (
      .clk (clk), .rst_n (rst_core_n), .clr (clr), .adv (adv),
      .din (a_gate), .dout (a_edge[l])
    );
    os_sa_skew #(.DEPTH(l), .W(OPW)) u_skew_b (
      .clk (clk), .rst_n (rst_core_n), .clr (clr), .adv (adv),
      .din (b_gate), .dout (b_edge[l])
    );
  end

  // operand hop registers: a moves right, b moves down, one hop per advance
  logic [OPW-1:0] a_hop_q [N][N-1];
  logic [OPW-1:0] b_hop_q [N-1][N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N-1; c++) begin
          a_hop_q[r][c] <= '0;
          b_hop_q[c][r] <= '0;
        end
    end else if (!rst_core_n || clr) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N-1; c++) begin
          a_hop_q[r][c] <= '0;
          b_hop_q[c][r] <= '0;
        end
    end else if (adv) begin
      for (int r = 0; r < N; r++) begin
        a_hop_q[r][0] <= a_edge[r];
        b_hop_q[0][r] <= b_edge[r];
        for (int c = 1; c < N-1; c++) begin
          a_hop_q[r][c] <= a_hop_q[r][c-1];
          b_hop_q[c][r] <= b_hop_q[c-1][r];
        end
      end
    end
  end

  logic [ACC_W-1:0] acc_grid [N][N];

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      logic [OPW-1:0] a_pe, b_pe;
      if (j == 0) begin : g_a_edge
        assign a_pe = a_edge[i];
      end else begin : g_a_hop
        assign a_pe = a_hop_q[i][j-1];
      end
      if (i == 0) begin : g_b_edge
        assign b_pe = b_edge[j];
      end else begin : g_b_hop
        assign b_pe = b_hop_q[i-1][j];
      end

      os_sa_pe #(.OPW(OPW), .ACC_W(ACC_W)) u_pe (
        .clk   (clk),
        .rst_n (rst_core_n),
        .clr   (clr),
        .adv   (adv),
        .a_in  (a_pe),
        .b_in  (b_pe),
        .acc   (acc_grid[i][j])
      );
    end
  end

  assign rd_data = acc_grid[rd_row][rd_col];

endmodule

// File: rtl/os_systolic_mm_chk.sv
module os_systolic_mm_chk #(
  parameter  int N     = 4,
  parameter  int K     = 16,
  localparam int ACC_W = os_sa_pkg::acc_width(K),
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             in_valid,
  input logic [IW-1:0]    rd_row,
  input logic [IW-1:0]    rd_col,
  input logic             done,
  input logic [ACC_W-1:0] rd_data
);

  // independent bookkeeping of the tile seen at the ports
  logic active;
  int   nacc, cyc, stalls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      nacc   <= 0;
      cyc    <= 0;
      stalls <= 0;
    end else if (start) begin
      active <= 1'b1;
      nacc   <= 0;
      cyc    <= 0;
      stalls <= 0;
    end else if (active) begin
      if (in_valid && nacc < K) nacc <= nacc + 1;
      if (nacc == 0 && in_valid) cyc <= 1;
      else if (nacc > 0)         cyc <= cyc + 1;
      if (nacc > 0 && nacc < K && !in_valid) stalls <= stalls + 1;
      if (done) active <= 1'b0;
    end
  end

  // R4 and R5: done rises K+2N-1 cycles after the first step, plus stalls
  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cyc == K + 2*N - 1 + stalls));

  // R4: no done while steps are still outstanding
  p_no_early_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && nacc < K) |-> !done);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R7 and R8: with the address held, results do not move while done
  p_valid_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (!$stable(rd_row) || !$stable(rd_col) || $stable(rd_data)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((longint'($signed(rd_data)) <= 64'sd16384 * K) &&
     (longint'($signed(rd_data)) >= -64'sd16256 * K)));

endmodule

bind os_systolic_mm os_systolic_mm_chk #(.N(N), .K(K)) u_chk (.*);

// File: tb/os_systolic_mm_bench.sv
module os_systolic_mm_bench;

  localparam int N     = 4;
  localparam int K     = 16;
  localparam int ACC_W = os_sa_pkg::acc_width(K);
  localparam int IW    = $clog2(N);

  logic             clk;
  logic             rst_n;
  logic             start;
  logic             in_valid;
  logic [N*8-1:0]   in_a;
  logic [N*8-1:0]   in_b;
  logic [IW-1:0]    rd_row;
  logic [IW-1:0]    rd_col;
  logic             done;
  logic [ACC_W-1:0] rd_data;

  os_systolic_mm #(.N(N), .K(K)) u_os_systolic_mm (
    .clk (clk), .rst_n (rst_n), .start (start), .in_valid (in_valid),
    .in_a (in_a), .in_b (in_b), .rd_row (rd_row), .rd_col (rd_col),
    .done (done), .rd_data (rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit model_on = 0;

  // behavioural reference: running sums and a done countdown
  longint exp_c [N][N];
  bit     m_active;
  int     m_nacc;
  int     m_cd;
  bit     done_exp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_nacc = 0; m_cd = -1; done_exp = 0;
      for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) exp_c[i][j] = 0;
    end else if (start) begin
      m_active = 1; m_nacc = 0; m_cd = -1; done_exp = 0;
      for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) exp_c[i][j] = 0;
    end else if (m_active) begin
      if (in_valid && m_nacc < K) begin
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++)
            exp_c[i][j] += longint'($signed(in_a[i*8 +: 8])) * longint'($signed(in_b[j*8 +: 8]));
        m_nacc++;
        if (m_nacc == K) m_cd = 2*N - 1;
      end else if (m_cd > 0) begin
        m_cd--;
        if (m_cd == 0) begin
          done_exp = 1;
          m_active = 0;
        end
      end
    end
  end

  int done_fail_prints = 0;
  always @(negedge clk) begin
    if (model_on && !finished) begin
      checks++;
      if (done !== done_exp) begin
        errors++;
        if (done_fail_prints < 10)
          $display("FAIL R4/R5 done per-cycle: actual %b expected %b at %0t", done, done_exp, $time);
        done_fail_prints++;
      end
    end
  end

  function automatic int opnd(input int pat, input int k, input int lane, input int isb);
    case (pat)
      0: return ((k*73 + lane*29 + isb*151 + 17) % 256) - 128;
      1: return -128;
      2: return (isb != 0) ? 127 : -128;
      3: return (isb != 0) ? (((k % N) == lane) ? 1 : -1) : (k - lane*3);
      default: return (k*5 + lane) % 256 - 128;
    endcase
  endfunction

  task automatic pulse_start(input bit with_valid);
    @(negedge clk);
    start = 1'b1;
    in_valid = with_valid;
    in_a = {N{8'h7f}};
    in_b = {N{8'h7f}};
    @(negedge clk);
    start = 1'b0;
    in_valid = 1'b0;
  endtask

  // present n_steps of pattern pat; stall_mode 1 inserts k%3 gaps before step k
  task automatic feed(input int pat, input int n_steps, input int stall_mode);
    for (int k = 0; k < n_steps; k++) begin
      if (stall_mode == 1) begin
        for (int g = 0; g < (k % 3); g++) begin
          in_valid = 1'b0;
          in_a = {N{8'h55}};
          in_b = {N{8'ha3}};
          @(negedge clk);
        end
      end
      in_valid = 1'b1;
      for (int l = 0; l < N; l++) begin
        in_a[l*8 +: 8] = 8'(opnd(pat, k, l, 0));
        in_b[l*8 +: 8] = 8'(opnd(pat, k, l, 1));
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done_exp && n < 300) begin
      @(negedge clk);
      n++;
    end
    checks++;
    if (done !== 1'b1) begin
      errors++;
      $display("FAIL %s done at finish: actual %b expected 1", req, done);
    end
  endtask

  task automatic check_results(input string req);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        rd_row = IW'(i);
        rd_col = IW'(j);
        #1;
        checks++;
        if (longint'($signed(rd_data)) != exp_c[i][j]) begin
          errors++;
          $display("FAIL %s C[%0d][%0d]: actual %0d expected %0d", req, i, j,
                   $signed(rd_data), exp_c[i][j]);
        end
      end
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0;
    in_a = '0; in_b = '0; rd_row = '0; rd_col = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_on = 1;

    // R1: reset state
    checks++;
    if (done !== 1'b0) begin
      errors++;
      $display("FAIL R1 done after reset: actual %b expected 0", done);
    end
    check_results("R1");

    // R2, R4: scrambled mixed-sign tile, no gaps
    pulse_start(1'b0);
    feed(0, K, 0);
    wait_done("R4");
    check_results("R2 scrambled");

    // R2: ramp against +/-1 selector
    pulse_start(1'b0);
    feed(3, K, 0);
    wait_done("R4");
    check_results("R2 ramp");

    // R3: extreme operands
    pulse_start(1'b0);
    feed(1, K, 0);
    wait_done("R3");
    check_results("R3 max");
    checks++;
    if (exp_c[0][0] != 64'sd16384 * K) begin
      errors++;
      $display("FAIL R3 reference sum: actual %0d expected %0d", exp_c[0][0], 16384*K);
    end
    pulse_start(1'b0);
    feed(2, K, 0);
    wait_done("R3");
    check_results("R3 min");

    // R5: gapped feed of the scrambled pattern
    pulse_start(1'b0);
    feed(0, K, 1);
    wait_done("R5");
    check_results("R5 stalls");

    // R7: valid with start, valid during flush and after done
    pulse_start(1'b1);
    feed(3, K, 0);
    in_valid = 1'b1;
    in_a = {N{8'h80}};
    in_b = {N{8'h80}};
    wait_done("R7");
    repeat (6) @(negedge clk);
    in_valid = 1'b0;
    check_results("R7 ignored valid");

    // R8: done and results hold over idle cycles
    repeat (10) @(negedge clk);
    checks++;
    if (done !== 1'b1) begin
      errors++;
      $display("FAIL R8 done hold: actual %b expected 1", done);
    end
    check_results("R8 hold");

    // R6: restart in the middle of a tile
    pulse_start(1'b0);
    feed(1, K/2, 0);
    pulse_start(1'b0);
    checks++;
    if (done !== 1'b0) begin
      errors++;
      $display("FAIL R6 done after restart: actual %b expected 0", done);
    end
    feed(0, K, 0);
    wait_done("R6");
    check_results("R6 restart");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule